// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block decides which single interrupt cause a 16550-style serial port reports, and drives the port's interrupt line. It collects five cause sources: receive line errors, the receive character timeout, receive data available, transmit holding register empty, and modem line changes. It masks each source with a four-bit enable register. It then picks the most urgent unmasked source and encodes it into an identification byte that software reads to find out why it was interrupted.

The block sits beside the serial shifters, the baud generator and the FIFO storage, none of which it contains. The receive path gives it data-ready, the FIFO fill count and trigger level, the timeout flag, and live parity and framing error levels. It also gives one-cycle pulses for overrun and break events. The transmit path pulses when the holding register empties and when the shifter goes idle. The modem side gives line levels and pulses for line changes.

Software reaches the block through a small byte-wide register port. The block owns the side effects of that port. Reading a register can clear pending causes. Writing the holding register or the enable register can arm or clear the transmit-empty cause.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register is 0, the FIFO mode is off, and the holding-empty and transmitter-empty status bits are 1. No cause is pending, the identification byte reads 0x01 and irq is low. The line status byte reads 0x60.
- R2: Among enabled sources the highest priority wins, in this order: line status (code 0x6), character timeout (0xC), receive data (0x4), transmit empty (0x2), modem change (0x0). Code 0x1 means nothing is pending. The code occupies identification bits 3:0.
- R3: The line status source is enabled by enable bit 2 and fires when any of overrun, parity, framing or break is set. The line status byte (address 3) is {0, txEmpty, holdEmpty, break, framing, parity, overrun, dataReady} from bit 7 down to bit 0.
- R4: The character timeout source has no enable of its own: enable bit 0 (receive data) masks it.
- R5: The receive data source is enabled by enable bit 0. With FIFO mode off it fires whenever dataReady is high. With FIFO mode on it fires only when the fill count is at or above the trigger level.
- R6: Reading the identification byte (address 2) while it shows code 0x2 clears the transmit-empty pending flag. A read that shows any other code leaves the flag alone.
- R7: A write to the enable register (address 1) that changes bit 1 sets the transmit-empty pending flag when the new bit 1 is 1 and the holding register is empty, and clears the flag otherwise. A write that leaves bit 1 unchanged does not touch the flag.
- R8: Reading the line status byte clears the stored break and overrun bits. Reading the modem byte (address 4, read as {lines[3:0], deltas[3:0]}) clears the four stored delta bits.
- R9: A write to the holding register (address 0) clears the pending flag and the holding-empty and transmitter-empty bits. A holding-empty pulse sets holding-empty and the pending flag. A transmitter-idle pulse sets transmitter-empty.
- R10: A write of bit 0 to address 2 selects FIFO mode. Identification bits 7:6 read 11 in FIFO mode and 00 otherwise, and bits 5:4 always read 0.
- R11: irq is registered. It is high in the cycle after the identification code is not 0x1, and low in the cycle after the code is 0x1. Read and write side effects show in the cycle after the strobe.
- R12: An overrun, break or modem-change event that arrives in the same cycle as the read that clears it is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the addressed register |
| parityErr | input | 1 | Live parity error of the character at the receive head |
| framingErr | input | 1 | Live framing error of the character at the receive head |
| setOverrun | input | 1 | Overrun event pulse |
| setBreak | input | 1 | Break event pulse |
| dataReady | input | 1 | Receive data present |
| fifoCount | input | CNT_W | Receive FIFO fill count |
| trigLevel | input | CNT_W | Receive FIFO trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| holdEmptySet | input | 1 | Holding register emptied pulse |
| txIdleSet | input | 1 | Transmit shifter idle pulse |
| modemDeltaSet | input | 4 | Modem line change pulses |
| modemLines | input | 4 | Modem line levels |
| identOut | output | 8 | Current identification byte |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- A pending, enabled line-status cause always wins the identification code.
- The timeout code never shows with the receive data enable off.
- The identification upper bits keep their fixed form.
- irq follows the code by exactly one cycle.
- A holding write, a line-status read and a same-cycle break event leave the stored state as required.

Some behaviour only the bench's scenarios can show: the full order among all five sources, the FIFO trigger comparison at and below the level, and the re-arming of transmit-empty when its enable bit toggles. The bench also shows that an identification read clears the pending flag only when it shows transmit-empty.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int ENA_W  = 4;
  localparam int MDM_W  = 4;
  localparam int ID_W   = 4;

  // register addresses
  localparam logic [ADDR_W-1:0] A_TX    = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENA   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDENT = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODEM = 3'd4;

  // enable register bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_THE  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  // identification codes
  localparam logic [ID_W-1:0] ID_LINE = 4'h6;
  localparam logic [ID_W-1:0] ID_TMO  = 4'hC;
  localparam logic [ID_W-1:0] ID_RXD  = 4'h4;
  localparam logic [ID_W-1:0] ID_THE  = 4'h2;
  localparam logic [ID_W-1:0] ID_MDM  = 4'h0;
  localparam logic [ID_W-1:0] ID_NONE = 4'h1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENA,
    SEL_IDENT,
    SEL_LINE,
    SEL_MODEM
  } rdSel_e;

  typedef struct packed {
    logic wrTx;
    logic wrEna;
    logic wrFifo;
    logic rdIdent;
    logic rdLine;
    logic rdModem;
  } ctlStrb_t;

endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
(
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrb_t          strb,
  output rdSel_e            rdSel
);

  always_comb begin
    strb         = '0;
    strb.wrTx    = busWr && (busAddr == A_TX);
    strb.wrEna   = busWr && (busAddr == A_ENA);
    strb.wrFifo  = busWr && (busAddr == A_IDENT);
    strb.rdIdent = busRd && (busAddr == A_IDENT);
    strb.rdLine  = busRd && (busAddr == A_LINE);
    strb.rdModem = busRd && (busAddr == A_MODEM);
  end

  always_comb begin
    unique case (busAddr)
      A_ENA:   rdSel = SEL_ENA;
      A_IDENT: rdSel = SEL_IDENT;
      A_LINE:  rdSel = SEL_LINE;
      A_MODEM: rdSel = SEL_MODEM;
      default: rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [ENA_W-1:0] ena,
  input  logic             lineAny,
  input  logic             tmoPend,
  input  logic             rxReady,
  input  logic             thrPend,
  input  logic             mdmAny,
  output logic [ID_W-1:0]  code
);

  // R2 fixed order; R4 timeout gated by the receive data enable
  always_comb begin
    if (ena[EN_LINE] && lineAny)      code = ID_LINE;
    else if (ena[EN_RXD] && tmoPend)  code = ID_TMO;
    else if (ena[EN_RXD] && rxReady)  code = ID_RXD;
    else if (ena[EN_THE] && thrPend)  code = ID_THE;
    else if (ena[EN_MDM] && mdmAny)   code = ID_MDM;
    else                              code = ID_NONE;
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              parityErr,
  input  logic              framingErr,
  input  logic              setOverrun,
  input  logic              setBreak,
  input  logic              dataReady,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              timeoutPend,
  input  logic              holdEmptySet,
  input  logic              txIdleSet,
  input  logic [MDM_W-1:0]  modemDeltaSet,
  input  logic [MDM_W-1:0]  modemLines,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] identOut,
  output logic              irq
);

  logic [ENA_W-1:0] ena;
  logic             fifoEn;
  logic             ovrSt, brkSt;
  logic             holdEmpty, txEmpty, thrPend;
  logic [MDM_W-1:0] mdmDelta;
  logic             irqQ;
  logic [ID_W-1:0]  code;
  logic             lineAny, rxReady;
  logic [DATA_W-1:0] lineByte, modemByte;
  logic             unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:ENA_W];

  // R3 line cause, R5 receive data condition
  assign lineAny = ovrSt | parityErr | framingErr | brkSt;
  assign rxReady = dataReady & (~fifoEn | (fifoCount >= trigLevel));

  uart_irq_prio u_prio (
    .ena     (ena),
    .lineAny (lineAny),
    .tmoPend (timeoutPend),
    .rxReady (rxReady),
    .thrPend (thrPend),
    .mdmAny  (|mdmDelta),
    .code    (code)
  );

  // R10 upper bits mirror FIFO mode
  assign identOut  = {fifoEn, fifoEn, 2'b00, code};
  assign lineByte  = {1'b0, txEmpty, holdEmpty, brkSt, framingErr, parityErr, ovrSt, dataReady};
  assign modemByte = {modemLines, mdmDelta};
  assign irq       = irqQ;

  always_comb begin
    unique case (rdSel)
      SEL_ENA:   rdData = {{(DATA_W-ENA_W){1'b0}}, ena};
      SEL_IDENT: rdData = identOut;
      SEL_LINE:  rdData = lineByte;
      SEL_MODEM: rdData = modemByte;
      default:   rdData = '0;
    endcase
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ena    <= '0;
      fifoEn <= 1'b0;
    end else begin
      if (strb.wrEna)  ena    <= wrData[ENA_W-1:0];
      if (strb.wrFifo) fifoEn <= wrData[0];
    end
  end

  // R8/R12 sticky receive events: a new event wins over a clearing read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrSt    <= 1'b0;
      brkSt    <= 1'b0;
      mdmDelta <= '0;
    end else begin
      if (setOverrun)       ovrSt <= 1'b1;
      else if (strb.rdLine) ovrSt <= 1'b0;
      if (setBreak)         brkSt <= 1'b1;
      else if (strb.rdLine) brkSt <= 1'b0;
      mdmDelta <= (mdmDelta & ~{MDM_W{strb.rdModem}}) | modemDeltaSet;
    end
  end

  // R6/R7/R9 transmit status and pending flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdEmpty <= 1'b1;
      txEmpty   <= 1'b1;
      thrPend   <= 1'b0;
    end else begin
      if (strb.wrTx)        holdEmpty <= 1'b0;
      else if (holdEmptySet) holdEmpty <= 1'b1;
      if (strb.wrTx)        txEmpty <= 1'b0;
      else if (txIdleSet)   txEmpty <= 1'b1;
      if (strb.wrTx)
        thrPend <= 1'b0;
      else if (holdEmptySet)
        thrPend <= 1'b1;
      else if (strb.wrEna && (wrData[EN_THE] != ena[EN_THE]))
        thrPend <= wrData[EN_THE] & holdEmpty;
      else if (strb.rdIdent && (code == ID_THE))
        thrPend <= 1'b0;
    end
  end

  // R11 registered interrupt line
  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= (code != ID_NONE);
  end

  // R3 / R2: an enabled line cause always owns the code
  a_r3_line_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ena[EN_LINE] && lineAny) |-> (identOut[3:0] == ID_LINE));

  // R4: timeout never reported with receive data enable off
  a_r4_tmo_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ena[EN_RXD] |-> (identOut[3:0] != ID_TMO));

  // R10: fixed form of upper bits
  a_r10_upper_bits: assert property (@(posedge clk) disable iff (!rstN)
    (identOut[7] == identOut[6]) && (identOut[5:4] == 2'b00));

  // R11: irq follows the code one cycle later
  a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (identOut[3:0] != ID_NONE) |=> irq);
  a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    (identOut[3:0] == ID_NONE) |=> !irq);

  // R9: holding write empties status and pending flag
  a_r9_tx_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTx |=> (!thrPend && !holdEmpty && !txEmpty));

  // R8: line status read clears stored break and overrun
  a_r8_line_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLine && !setBreak && !setOverrun) |=> (!brkSt && !ovrSt));

  // R12: a break event is never lost
  a_r12_break_kept: assert property (@(posedge clk) disable iff (!rstN)
    setBreak |=> brkSt);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              parityErr,
  input  logic              framingErr,
  input  logic              setOverrun,
  input  logic              setBreak,
  input  logic              dataReady,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              timeoutPend,
  input  logic              holdEmptySet,
  input  logic              txIdleSet,
  input  logic [MDM_W-1:0]  modemDeltaSet,
  input  logic [MDM_W-1:0]  modemLines,
  output logic [DATA_W-1:0] identOut,
  output logic              irq
);

  ctlStrb_t strb;
  rdSel_e   rdSel;

  uart_irq_ctl u_ctl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .rdSel         (rdSel),
    .wrData        (busWrData),
    .parityErr     (parityErr),
    .framingErr    (framingErr),
    .setOverrun    (setOverrun),
    .setBreak      (setBreak),
    .dataReady     (dataReady),
    .fifoCount     (fifoCount),
    .trigLevel     (trigLevel),
    .timeoutPend   (timeoutPend),
    .holdEmptySet  (holdEmptySet),
    .txIdleSet     (txIdleSet),
    .modemDeltaSet (modemDeltaSet),
    .modemLines    (modemLines),
    .rdData        (busRdData),
    .identOut      (identOut),
    .irq           (irq)
  );

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  import uart_irq_pkg::*;

  localparam int CNT_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic              busWr, busRd;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWrData, busRdData;
  logic              parityErr, framingErr, setOverrun, setBreak;
  logic              dataReady, timeoutPend, holdEmptySet, txIdleSet;
  logic [CNT_W-1:0]  fifoCount, trigLevel;
  logic [MDM_W-1:0]  modemDeltaSet, modemLines;
  logic [DATA_W-1:0] identOut;
  logic              irq;

  uart_irq_ident #(.CNT_W(CNT_W)) u_uart_irq_ident (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .parityErr(parityErr),
    .framingErr(framingErr), .setOverrun(setOverrun), .setBreak(setBreak),
    .dataReady(dataReady), .fifoCount(fifoCount), .trigLevel(trigLevel),
    .timeoutPend(timeoutPend), .holdEmptySet(holdEmptySet), .txIdleSet(txIdleSet),
    .modemDeltaSet(modemDeltaSet), .modemLines(modemLines),
    .identOut(identOut), .irq(irq)
  );

  typedef struct {
    logic [7:0] ident;
    logic       irqV;
    logic       chkRd;
    logic [7:0] rd;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // monitor: compares queued expectations away from the clock edge
  initial forever begin
    @(negedge clk);
    #1;
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (identOut !== it.ident || irq !== it.irqV ||
          (it.chkRd && busRdData !== it.rd)) begin
        fails++;
        $display("FAIL %s: ident=%h irq=%b rd=%h expected ident=%h irq=%b rd=%h",
                 it.tag, identOut, irq, busRdData, it.ident, it.irqV, it.rd);
      end
    end
  end

  task automatic pushExp(input logic [7:0] id, input logic ir, input string tag);
    expQ.push_back('{id, ir, 1'b0, 8'h00, tag});
  endtask

  task automatic pushRd(input logic [7:0] id, input logic ir, input logic [7:0] rd,
                        input string tag);
    expQ.push_back('{id, ir, 1'b1, rd, tag});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    busWr = 0; busRd = 0; busAddr = '0; busWrData = '0;
    setOverrun = 0; setBreak = 0; holdEmptySet = 0; txIdleSet = 0;
    modemDeltaSet = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    busWr = 1; busAddr = a; busWrData = d;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    busRd = 1; busAddr = a;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R11: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; quiet();
    parityErr = 0; framingErr = 0; dataReady = 0; timeoutPend = 0;
    fifoCount = '0; trigLevel = '0; modemLines = '0;
    repeat (3) step();
    rstN = 1;
    quiet(); rd(A_LINE); pushRd(8'h01, 0, 8'h60, "R1 reset state"); step();
    // R7 enabling transmit-empty arms the flag
    quiet(); wr(A_ENA, 8'h02); pushExp(8'h01, 0, "R7 before arm"); step();
    quiet(); pushExp(8'h02, 0, "R7 armed by enable"); step();
    quiet(); pushExp(8'h02, 1, "R11 irq rises"); step();
    // R6 ident read clears transmit-empty
    quiet(); rd(A_IDENT); pushRd(8'h02, 1, 8'h02, "R6 ident read"); step();
    quiet(); pushExp(8'h01, 1, "R6 cleared by read"); step();
    quiet(); pushExp(8'h01, 0, "R11 irq falls"); step();
    // R7 toggle re-arms, unchanged bit keeps flag
    quiet(); wr(A_ENA, 8'h00); step();
    quiet(); wr(A_ENA, 8'h02); step();
    quiet(); wr(A_ENA, 8'h03); pushExp(8'h02, 0, "R7 re-armed by toggle"); step();
    quiet(); pushExp(8'h02, 1, "R7 unchanged bit keeps flag"); step();
    // R9 holding write and transmit pulses
    quiet(); wr(A_TX, 8'h55); step();
    quiet(); rd(A_LINE); pushRd(8'h01, 1, 8'h00, "R9 holding write clears"); step();
    quiet(); holdEmptySet = 1; step();
    quiet(); rd(A_LINE); pushRd(8'h02, 0, 8'h20, "R9 holding empty pulse"); step();
    quiet(); txIdleSet = 1; step();
    quiet(); rd(A_LINE); pushRd(8'h02, 1, 8'h60, "R9 idle pulse"); step();
    // R5 / R2 receive sources
    quiet(); dataReady = 1; pushExp(8'h04, 1, "R5 data ready fifo off"); step();
    quiet(); timeoutPend = 1; pushExp(8'h0C, 1, "R2 timeout over data"); step();
    quiet(); wr(A_ENA, 8'h02); step();
    quiet(); pushExp(8'h02, 1, "R4 timeout masked by rx enable"); step();
    quiet(); wr(A_ENA, 8'h07); step();
    quiet(); parityErr = 1; pushExp(8'h06, 1, "R3 parity line cause"); step();
    quiet(); parityErr = 0; setOverrun = 1; pushExp(8'h0C, 1, "R2 timeout after parity"); step();
    quiet(); rd(A_LINE); pushRd(8'h06, 1, 8'h63, "R3 overrun line byte"); step();
    quiet(); pushExp(8'h0C, 1, "R8 overrun cleared by read"); step();
    quiet(); rd(A_LINE); setBreak = 1; pushRd(8'h0C, 1, 8'h61, "R12 read with break"); step();
    quiet(); pushExp(8'h06, 1, "R12 break kept"); step();
    quiet(); rd(A_LINE); pushRd(8'h06, 1, 8'h71, "R8 break visible"); step();
    quiet(); pushExp(8'h0C, 1, "R8 break cleared"); step();
    quiet(); timeoutPend = 0; pushExp(8'h04, 1, "R2 data over transmit"); step();
    quiet(); dataReady = 0; pushExp(8'h02, 1, "R2 transmit empty"); step();
    // modem source
    quiet(); wr(A_ENA, 8'h08); modemDeltaSet = 4'h5; step();
    quiet(); pushExp(8'h00, 1, "R2 modem cause"); step();
    quiet(); modemLines = 4'hA; rd(A_MODEM); pushRd(8'h00, 1, 8'hA5, "R8 modem byte"); step();
    quiet(); pushExp(8'h01, 1, "R8 deltas cleared"); step();
    quiet(); pushExp(8'h01, 0, "R11 irq low"); step();
    quiet(); wr(A_ENA, 8'h0A); modemDeltaSet = 4'h1; step();
    quiet(); pushExp(8'h02, 0, "R2 transmit over modem"); step();
    quiet(); rd(A_IDENT); pushRd(8'h02, 1, 8'h02, "R6 ident read transmit"); step();
    quiet(); pushExp(8'h00, 1, "R6 modem exposed after clear"); step();
    quiet(); rd(A_MODEM); pushRd(8'h00, 1, 8'hA1, "R8 modem read"); step();
    quiet(); pushExp(8'h01, 1, "R8 modem cleared"); step();
    // R6 read of another code keeps the flag
    quiet(); wr(A_ENA, 8'h08); step();
    quiet(); wr(A_ENA, 8'h0B); step();
    quiet(); dataReady = 1; pushExp(8'h04, 0, "R5 data with transmit pending"); step();
    quiet(); rd(A_IDENT); pushRd(8'h04, 1, 8'h04, "R6 ident read other code"); step();
    quiet(); dataReady = 0; pushExp(8'h02, 1, "R6 flag survives other read"); step();
    quiet(); rd(A_IDENT); step();
    // R10 / R5 FIFO mode
    quiet(); wr(A_IDENT, 8'h01); pushExp(8'h01, 1, "R10 before fifo on"); step();
    quiet(); pushExp(8'hC1, 0, "R10 fifo bits set"); step();
    quiet(); trigLevel = 5'd4; fifoCount = 5'd3; dataReady = 1;
    pushExp(8'hC1, 0, "R5 below trigger"); step();
    quiet(); fifoCount = 5'd4; pushExp(8'hC4, 0, "R5 at trigger"); step();
    quiet(); fifoCount = 5'd5; pushExp(8'hC4, 1, "R5 above trigger"); step();
    quiet(); wr(A_IDENT, 8'h00); step();
    quiet(); fifoCount = 5'd0; pushExp(8'h04, 1, "R10 fifo off bits clear"); step();
    quiet(); dataReady = 0; pushExp(8'h01, 1, "R5 no data"); step();
    step();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule